// File: doc/BRIEF.md
# Signaling NaN Screen and Quieting Stage

This stage sits on the operand-to-result path of a floating-point unit. Each accepted operation presents one extended-precision source operand, a destination format, the user enable for signaling-NaN traps, a flag for the status-neutral instruction class (multi-register moves, control-register moves, state saves) and a flag that asks for a freshly generated NaN (invalid operation). One cycle later the stage returns the value for the destination, a write enable, the one-cycle request to set the SNaN bit of the exception-status byte, and a one-cycle pulse for an immediate non-maskable trap.

A signaling NaN bound for a floating destination is either quieted and written (trap disabled) or held back as a pending trap (trap enabled). The pending trap is reported as a pre-instruction exception when the next floating-point instruction issues. Integer destinations (byte, word, long) always trap at once. The stage never emits a signaling NaN: any NaN it writes to a floating destination has its quiet bit set.

Top module: `snan_gate`

## Requirements
- R1: After reset `out_valid`, `pending`, `post_trap` and `pre_trap` are 0, and `in_ready` is 1 from the first clock edge after reset is released.
- R2: An operand is a signaling NaN when bits [78:64] are all ones, bit 62 is 0 and bits [61:0] are non-zero. For such an operand in a non-neutral instruction without `gen_nan`, `snan_set` is 1 in the result cycle; for any other operand it is 0.
- R3: Quieting for an extended destination (`dst_fmt`=3'b000) sets bit 62 and changes no other bit.
- R4: For a double destination (`dst_fmt`=3'b001) a NaN result is placed in bits [63:0] as sign, eleven ones, then operand bits [62:11] with the top one forced to 1; bits [79:64] are 0.
- R5: For a single destination (`dst_fmt`=3'b010) a NaN result is placed in bits [31:0] as sign, eight ones, then operand bits [62:40] with the top one forced to 1; bits [79:32] are 0.
- R6: A signaling NaN bound for a floating destination with `trap_en`=1 drives `res_we` to 0, gives no `post_trap`, and sets `pending`.
- R7: A signaling NaN bound for an integer destination (`dst_fmt` bit 2 set: 3'b100 byte, 3'b101 word, 3'b110 long) gives a one-cycle `post_trap`, `res_we`=0 and an unchanged operand on `res`, whatever `trap_en` is, and leaves `pending` untouched.
- R8: With `neutral`=1 the operand is passed unchanged with `res_we`=1, and no status bit, trap or pending flag results.
- R9: With `gen_nan`=1 the result is the default quiet NaN (sign 0, exponent all ones, bits 63 and 62 set, rest 0), narrowed as in R4/R5, and `snan_set` is 0.
- R10: `fp_issue` while `pending` is 1 gives a one-cycle `pre_trap` in the next cycle and clears `pending`; without a pending trap `fp_issue` has no effect.
- R11: A further enabled signaling NaN while a trap is pending keeps a single pending trap; one `fp_issue` drains it.
- R12: A quiet NaN is narrowed per R4/R5 without status; a non-NaN operand is passed unchanged with `res_we`=1 and no status.
- R13: `out_valid` is 1 exactly in the cycle after `in_valid` is accepted, with the outputs of that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Stage accepts an operation |
| operand | input | 80 | Extended source: sign, 15-bit exponent, 64-bit mantissa with explicit integer bit |
| dst_fmt | input | 3 | Destination format code |
| trap_en | input | 1 | User SNaN trap enable |
| neutral | input | 1 | Status-neutral instruction class |
| gen_nan | input | 1 | Produce a generated NaN instead of the operand |
| fp_issue | input | 1 | Next floating-point instruction issues |
| out_valid | output | 1 | Result cycle |
| res | output | 80 | Destination value |
| res_we | output | 1 | Destination may be written |
| snan_set | output | 1 | Set SNaN bit in the exception-status byte |
| post_trap | output | 1 | Immediate non-maskable trap pulse |
| pre_trap | output | 1 | Pre-instruction trap pulse |
| pending | output | 1 | Deferred trap pending |

## Verification
The in-design assertions watch on every cycle that no extended result written to a floating destination is signaling, that every trap or suppressed write comes with the SNaN status set, that a pre-instruction pulse is preceded by a pending flag, and that a new pending flag only follows an accepted operation. Exact bit layouts after narrowing, the split between quiet-through, deferred and immediate outcomes, the neutral class, and the single-slot pending behaviour across reset and repeated issues are shown only by the bench's vector walk and directed sequences.

// File: rtl/snan_pkg.sv
package snan_pkg;
    localparam int EXP_W  = 15;
    localparam int MAN_W  = 64;
    localparam int OP_W   = 1 + EXP_W + MAN_W;
    localparam int DBL_EW = 11;
    localparam int DBL_FW = 52;
    localparam int SGL_EW = 8;
    localparam int SGL_FW = 23;

    typedef enum logic [2:0] {
        FMT_EXT  = 3'b000,
        FMT_DBL  = 3'b001,
        FMT_SGL  = 3'b010,
        FMT_BYTE = 3'b100,
        FMT_WORD = 3'b101,
        FMT_LONG = 3'b110
    } fmt_e;

    typedef struct packed {
        logic            rdy;
        logic            valid;
        logic            we;
        logic            sset;
        logic            post;
        logic            pre;
        logic            pend;
        logic [OP_W-1:0] res;
    } gate_st_t;
endpackage

// File: rtl/snan_classify.sv
module snan_classify #(
    parameter int EW = snan_pkg::EXP_W,
    parameter int MW = snan_pkg::MAN_W,
    localparam int W = 1 + EW + MW
) (
    input  logic [W-1:0] val,
    output logic         is_nan,
    output logic         is_snan
);
    logic exp_ones;
    logic frac_nz;
    logic quiet_bit;

    always_comb begin
        exp_ones  = &val[MW +: EW];
        quiet_bit = val[MW-2];
        frac_nz   = |val[MW-2:0];
        is_nan    = exp_ones && frac_nz;
        is_snan   = exp_ones && !quiet_bit && (|val[MW-3:0]);
    end
endmodule

// File: rtl/snan_narrow.sv
module snan_narrow #(
    parameter int MW = snan_pkg::MAN_W,
    parameter int OW = snan_pkg::OP_W,
    parameter int NE = snan_pkg::DBL_EW,
    parameter int NF = snan_pkg::DBL_FW,
    localparam int PAD = OW - 1 - NE - NF
) (
    input  logic          sign,
    input  logic [MW-2:0] frac,
    output logic [OW-1:0] nan_out
);
    always_comb begin
        nan_out = {{PAD{1'b0}}, sign, {NE{1'b1}}, 1'b1, frac[MW-3 -: NF-1]};
    end
endmodule

// File: rtl/snan_gate.sv
module snan_gate
    import snan_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [OP_W-1:0] operand,
    input  logic [2:0]      dst_fmt,
    input  logic            trap_en,
    input  logic            neutral,
    input  logic            gen_nan,
    input  logic            fp_issue,
    output logic            out_valid,
    output logic [OP_W-1:0] res,
    output logic            res_we,
    output logic            snan_set,
    output logic            post_trap,
    output logic            pre_trap,
    output logic            pending
);
    localparam logic [OP_W-1:0] DEF_NAN = {1'b0, {EXP_W{1'b1}}, 2'b11, {(MAN_W-2){1'b0}}};

    gate_st_t st_d, st_q;

    logic            in_nan, in_snan;
    logic [OP_W-1:0] src;
    logic [OP_W-1:0] ext_q_val, dbl_val, sgl_val, fmt_val;
    logic            chk_nan, chk_snan;

    snan_classify #(.EW(EXP_W), .MW(MAN_W)) u_cls_in (
        .val(operand), .is_nan(in_nan), .is_snan(in_snan)
    );

    always_comb src = gen_nan ? DEF_NAN : operand;

    snan_narrow #(.MW(MAN_W), .OW(OP_W), .NE(DBL_EW), .NF(DBL_FW)) u_nar_dbl (
        .sign(src[OP_W-1]), .frac(src[MAN_W-2:0]), .nan_out(dbl_val)
    );
    snan_narrow #(.MW(MAN_W), .OW(OP_W), .NE(SGL_EW), .NF(SGL_FW)) u_nar_sgl (
        .sign(src[OP_W-1]), .frac(src[MAN_W-2:0]), .nan_out(sgl_val)
    );

    always_comb begin
        ext_q_val           = src;
        ext_q_val[MAN_W-2]  = 1'b1;
        case (dst_fmt)
            FMT_DBL: fmt_val = dbl_val;
            FMT_SGL: fmt_val = sgl_val;
            default: fmt_val = ext_q_val;
        endcase
    end

    snan_classify #(.EW(EXP_W), .MW(MAN_W)) u_cls_out (
        .val(fmt_val), .is_nan(chk_nan), .is_snan(chk_snan)
    );

    logic accept, int_dst, snan_hit, defer, immed, take;

    always_comb begin
        accept   = in_valid && st_q.rdy;
        int_dst  = dst_fmt[2];
        snan_hit = in_snan && !gen_nan && !neutral;
        immed    = snan_hit && int_dst;
        defer    = snan_hit && !int_dst && trap_en;
        take     = fp_issue && st_q.pend;

        st_d       = st_q;
        st_d.rdy   = 1'b1;
        st_d.valid = accept;
        st_d.pre   = take;
        st_d.pend  = (st_q.pend && !take) || (accept && defer);
        st_d.sset  = 1'b0;
        st_d.post  = 1'b0;
        st_d.we    = 1'b0;
        if (accept) begin
            st_d.sset = snan_hit;
            st_d.post = immed;
            st_d.we   = !(immed || defer);
            if (neutral || int_dst || !(in_nan || gen_nan))
                st_d.res = operand;
            else
                st_d.res = fmt_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        in_ready  = st_q.rdy;
        out_valid = st_q.valid;
        res       = st_q.res;
        res_we    = st_q.we;
        snan_set  = st_q.sset;
        post_trap = st_q.post;
        pre_trap  = st_q.pre;
        pending   = st_q.pend;
    end

    // R3
    ext_never_snan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (dst_fmt == FMT_EXT) && (in_nan || gen_nan)) |-> !chk_snan);

    // R7
    trap_has_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !res_we) |-> snan_set);

    // R7
    post_in_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        post_trap |-> out_valid);

    // R10
    pre_after_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_trap |-> $past(pending));

    // R6
    pend_from_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> (out_valid && !res_we && !post_trap));
endmodule

// File: tb/tb_snan_gate.sv
module tb_snan_gate;
    import snan_pkg::*;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [OP_W-1:0] operand = '0;
    logic [2:0]      dst_fmt = 3'b000;
    logic            trap_en = 1'b0;
    logic            neutral = 1'b0;
    logic            gen_nan = 1'b0;
    logic            fp_issue = 1'b0;
    logic            out_valid;
    logic [OP_W-1:0] res;
    logic            res_we, snan_set, post_trap, pre_trap, pending;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    snan_gate dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .operand(operand), .dst_fmt(dst_fmt), .trap_en(trap_en), .neutral(neutral),
        .gen_nan(gen_nan), .fp_issue(fp_issue), .out_valid(out_valid), .res(res),
        .res_we(res_we), .snan_set(snan_set), .post_trap(post_trap),
        .pre_trap(pre_trap), .pending(pending)
    );

    typedef struct packed {
        logic [7:0]      req;
        logic [79:0]     op;
        logic [2:0]      fmt;
        logic            en;
        logic            neu;
        logic            gen;
        logic [79:0]     exp_res;
        logic            exp_we;
        logic            exp_ss;
        logic            exp_post;
        logic            exp_pend;
    } vec_t;

    localparam logic [79:0] SN1 = 80'hFFFF_8000_0000_0000_0800;
    localparam logic [79:0] SN2 = 80'h7FFF_8000_0100_0000_0000;
    localparam logic [79:0] QN  = 80'h7FFF_C000_0000_0000_0000;
    localparam logic [79:0] INF = 80'h7FFF_8000_0000_0000_0000;
    localparam logic [79:0] NRM = 80'h3FFF_8000_0000_0000_0000;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{8'd3,  SN1, 3'b000, 1'b0, 1'b0, 1'b0, 80'hFFFF_C000_0000_0000_0800, 1'b1, 1'b1, 1'b0, 1'b0}, // R3
        '{8'd4,  SN1, 3'b001, 1'b0, 1'b0, 1'b0, 80'h0000_FFF8_0000_0000_0001, 1'b1, 1'b1, 1'b0, 1'b0}, // R4
        '{8'd5,  SN1, 3'b010, 1'b0, 1'b0, 1'b0, 80'h0000_0000_0000_FFC0_0000, 1'b1, 1'b1, 1'b0, 1'b0}, // R5
        '{8'd5,  SN2, 3'b010, 1'b0, 1'b0, 1'b0, 80'h0000_0000_0000_7FC0_0001, 1'b1, 1'b1, 1'b0, 1'b0}, // R5
        '{8'd4,  SN2, 3'b001, 1'b0, 1'b0, 1'b0, 80'h0000_7FF8_0000_2000_0000, 1'b1, 1'b1, 1'b0, 1'b0}, // R4
        '{8'd6,  SN2, 3'b000, 1'b1, 1'b0, 1'b0, 80'h7FFF_C000_0100_0000_0000, 1'b0, 1'b1, 1'b0, 1'b1}, // R6
        '{8'd7,  SN1, 3'b100, 1'b0, 1'b0, 1'b0, SN1,                          1'b0, 1'b1, 1'b1, 1'b0}, // R7
        '{8'd7,  SN1, 3'b110, 1'b1, 1'b0, 1'b0, SN1,                          1'b0, 1'b1, 1'b1, 1'b0}, // R7
        '{8'd8,  SN1, 3'b101, 1'b0, 1'b1, 1'b0, SN1,                          1'b1, 1'b0, 1'b0, 1'b0}, // R8
        '{8'd8,  SN1, 3'b000, 1'b1, 1'b1, 1'b0, SN1,                          1'b1, 1'b0, 1'b0, 1'b0}, // R8
        '{8'd12, QN,  3'b001, 1'b1, 1'b0, 1'b0, 80'h0000_7FF8_0000_0000_0000, 1'b1, 1'b0, 1'b0, 1'b0}, // R12
        '{8'd12, INF, 3'b001, 1'b1, 1'b0, 1'b0, INF,                          1'b1, 1'b0, 1'b0, 1'b0}, // R12
        '{8'd12, NRM, 3'b000, 1'b1, 1'b0, 1'b0, NRM,                          1'b1, 1'b0, 1'b0, 1'b0}, // R12
        '{8'd9,  SN1, 3'b010, 1'b1, 1'b0, 1'b1, 80'h0000_0000_0000_7FC0_0000, 1'b1, 1'b0, 1'b0, 1'b0}, // R9
        '{8'd9,  NRM, 3'b000, 1'b0, 1'b0, 1'b1, QN,                           1'b1, 1'b0, 1'b0, 1'b0}, // R9
        '{8'd6,  SN1, 3'b001, 1'b1, 1'b0, 1'b0, 80'h0000_FFF8_0000_0000_0001, 1'b0, 1'b1, 1'b0, 1'b1}  // R6
    };

    task automatic chk(input string req, input string what, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive_op(input logic [79:0] op, input logic [2:0] fmt, input logic en,
                            input logic neu, input logic gen);
        @(negedge clk);
        in_valid = 1'b1; operand = op; dst_fmt = fmt; trap_en = en; neutral = neu; gen_nan = gen;
        @(posedge clk); #1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic issue();
        @(negedge clk);
        fp_issue = 1'b1;
        @(posedge clk); #1;
        @(negedge clk);
        fp_issue = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1", "out_valid in reset", {79'd0, out_valid}, 80'd0);
        chk("R1", "pending in reset", {79'd0, pending}, 80'd0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1", "in_ready after reset", {79'd0, in_ready}, 80'd1);
        chk("R1", "post/pre after reset", {78'd0, post_trap, pre_trap}, 80'd0);

        for (int i = 0; i < NV; i++) begin
            string rq;
            rq = $sformatf("R%0d", VECS[i].req);
            @(negedge clk);
            in_valid = 1'b1; operand = VECS[i].op; dst_fmt = VECS[i].fmt;
            trap_en = VECS[i].en; neutral = VECS[i].neu; gen_nan = VECS[i].gen;
            @(posedge clk); #1;
            chk("R13", "out_valid in result cycle", {79'd0, out_valid}, 80'd1);
            chk(rq, $sformatf("vec%0d res", i), res, VECS[i].exp_res);
            chk(rq, $sformatf("vec%0d we", i), {79'd0, res_we}, {79'd0, VECS[i].exp_we});
            chk("R2", $sformatf("vec%0d snan_set", i), {79'd0, snan_set}, {79'd0, VECS[i].exp_ss});
            chk(rq, $sformatf("vec%0d post", i), {79'd0, post_trap}, {79'd0, VECS[i].exp_post});
            chk(rq, $sformatf("vec%0d pending", i), {79'd0, pending}, {79'd0, VECS[i].exp_pend});
            @(negedge clk);
            in_valid = 1'b0; fp_issue = 1'b1;
            @(posedge clk); #1;
            chk("R13", "out_valid idle", {79'd0, out_valid}, 80'd0);
            chk("R7", "post pulse ends", {79'd0, post_trap}, 80'd0);
            chk("R10", $sformatf("vec%0d pre_trap", i), {79'd0, pre_trap}, {79'd0, VECS[i].exp_pend});
            chk("R10", "pending cleared", {79'd0, pending}, 80'd0);
            @(negedge clk);
            fp_issue = 1'b0;
            @(posedge clk); #1;
            chk("R10", "pre pulse ends", {79'd0, pre_trap}, 80'd0);
        end

        // R10: issue with nothing pending
        issue();
        chk("R10", "no pre_trap without pending", {79'd0, pre_trap}, 80'd0);

        // R11: two enabled SNaNs queue only one trap
        drive_op(SN1, 3'b000, 1'b1, 1'b0, 1'b0);
        drive_op(SN2, 3'b010, 1'b1, 1'b0, 1'b0);
        chk("R11", "pending after two", {79'd0, pending}, 80'd1);
        @(negedge clk); fp_issue = 1'b1;
        @(posedge clk); #1;
        chk("R11", "first issue traps", {79'd0, pre_trap}, 80'd1);
        @(posedge clk); #1;
        chk("R11", "second issue no trap", {79'd0, pre_trap}, 80'd0);
        chk("R11", "pending drained", {79'd0, pending}, 80'd0);
        @(negedge clk); fp_issue = 1'b0;

        // R7: integer trap leaves an existing pending flag
        drive_op(SN1, 3'b000, 1'b1, 1'b0, 1'b0);
        drive_op(SN1, 3'b101, 1'b1, 1'b0, 1'b0);
        chk("R7", "pending kept across int trap", {79'd0, pending}, 80'd1);

        // R1: reset clears pending
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        chk("R1", "reset clears pending", {79'd0, pending}, 80'd0);
        @(negedge clk); rst_n = 1'b1;
        issue();
        chk("R1", "no trap after reset", {79'd0, pre_trap}, 80'd0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule